// File: doc/BRIEF.md
# MII Management Serial Master

This block runs register reads and writes on the two-wire PHY management bus: a master-generated clock and a shared, bidirectional data line. A host hands over one command at a time on a small parallel interface. The command carries a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the whole serial frame. It drives the data line through an output value and an output-enable pair, so the pad logic outside the block builds the tri-state buffer. When the frame ends, the block returns the read data and an error flag.

The management clock is the system clock divided by the even parameter `CLK_DIV`. Each serial bit takes one bit slot of `CLK_DIV` system cycles. The clock is low for the first half of the slot and high for the second half. The master changes the data line at the start of a slot, so a PHY that samples on the rising edge sees a settled value. The master samples the line in the last system cycle of the low half of a slot.

The command side is a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. A valid that is held while the block is busy simply waits: it neither alters nor restarts the frame in progress. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse, and `rsp_rdata` and `rsp_err` are valid in that cycle and hold their values until the next command is accepted.

Top module: `mgmt_serial_master`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle. A command is accepted on a rising clock edge with `cmd_valid` and `cmd_ready` both high. While busy, the command inputs have no effect on the serial output, the response or the timing.
- R2: `busy` rises in the cycle after acceptance and stays high through the single cycle of `rsp_valid`. It is low in the following cycle.
- R3: Counting slots from 0 at acceptance, each slot lasts `CLK_DIV` cycles, with `mdc` low for the first `CLK_DIV/2` cycles and high for the rest. `mdc` is low whenever the block is idle.
- R4: Slots 0 to 31 form the preamble, with `mdio_oe`=1 and `mdio_o`=1.
- R5: Slots 32 to 45 carry 14 header bits, most significant first: start code 01, then the opcode (10 for a read, 01 for a write), then the PHY address, then the register address. `mdio_o` changes only while `mdc` is low.
- R6: For a write, slots 46 and 47 carry the turnaround bits 1 then 0. Slots 48 to 63 carry the write data, most significant first. Slot 64 is an idle slot driven high. `mdio_oe` is 0 in the response cycle.
- R7: For a read, `mdio_oe` is 0 from slot 46 to the end of the frame. Slot 46 is the idle slot, with `mdio_o`=0.
- R8: For a read, the acknowledge is sampled from `mdio_i` in the last low cycle of slot 47. A 0 means the PHY answered, and the read then ends with `rsp_err`=0.
- R9: On a good acknowledge, the 16 bits sampled in slots 48 to 63 form `rsp_rdata`, with the bit from slot 48 as bit 15.
- R10: On a missing acknowledge (1), slots 48 to 63 are still clocked. The block ends with `rsp_err`=1 and `rsp_rdata`=0.
- R11: Both reads and writes end after slot 64. `rsp_valid` is high in cycle 65*`CLK_DIV` after acceptance, with `mdc` and `mdio_oe` low. A write reports `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High while idle; a command is accepted when high together with valid |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_phy | input | 5 | PHY address |
| cmd_regad | input | 5 | Register address |
| cmd_wdata | input | 16 | Data to write |
| busy | output | 1 | Frame in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data (zero on error) |
| rsp_err | output | 1 | No acknowledge from the PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value while driving |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line level seen at the pad |

## Verification
Suppose the slot counter or the bit counter drifts by one position. The `mdc`/`mdio_oe`/`mdio_o` pattern then leaves the per-cycle reference within the same slot, and `rsp_valid` arrives in the wrong cycle, at most one frame later. A header or write-data shift-register fault shows as a wrong `mdio_o` level in the affected slot. A sampling point placed on the wrong cycle or the wrong slot only becomes visible at `rsp_rdata` or `rsp_err` in the response cycle. For that reason the bench drives PHY data that changes from slot to slot, plus all-ones and all-zeros words. A missing-acknowledge read checks that the 16 dummy slots and the trailing slot are still produced.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_LEN  = 32;
  localparam int HDR_LEN  = 4 + 2 * ADDR_W;
  localparam int WBODY_W  = HDR_LEN + 2 + DATA_W;

  localparam logic [1:0] CODE_START = 2'b01;
  localparam logic [1:0] CODE_RD    = 2'b10;
  localparam logic [1:0] CODE_WR    = 2'b01;
  localparam logic [1:0] CODE_TA    = 2'b10;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_WIDLE,
    ST_RIDLE,
    ST_ACK,
    ST_RDATA,
    ST_TRAIL,
    ST_DONE
  } mgmt_state_t;
endpackage

// File: rtl/mgmt_clk_gen.sv
module mgmt_clk_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic sample_pt,
  output logic slot_end
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] LAST_C = CW'(CLK_DIV - 1);
  localparam logic [CW-1:0] SAMP_C = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == LAST_C) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc       = run && (cnt_q >= HALF_C);
  assign sample_pt = run && (cnt_q == SAMP_C);
  assign slot_end  = run && (cnt_q == LAST_C);
endmodule

// File: rtl/mgmt_tx_shift.sv
module mgmt_tx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= load_word;
    end else if (shift) begin
      sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign msb = sh_q[W-1];
endmodule

// File: rtl/mgmt_rx_shift.sv
module mgmt_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         capture,
  input  logic         din,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
    end else if (clear) begin
      data <= '0;
    end else if (capture) begin
      data <= {data[W-2:0], din};
    end
  end
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_regad,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int BW = $clog2(WBODY_W);

  mgmt_state_t   state_q;
  logic [BW-1:0] bcnt_q;
  logic          is_rd_q;
  logic          err_q;
  logic          accept;
  logic          run;
  logic          sample_pt;
  logic          slot_end;
  logic          tx_msb;
  logic          rx_cap;
  logic [WBODY_W-1:0] tx_word;

  assign accept = cmd_valid && (state_q == ST_IDLE);
  assign run    = (state_q != ST_IDLE) && (state_q != ST_DONE);

  // Write frame: header, turnaround, data; a read uses only the header bits.
  assign tx_word = cmd_read
    ? {CODE_START, CODE_RD, cmd_phy, cmd_regad, {(2 + DATA_W){1'b0}}}
    : {CODE_START, CODE_WR, cmd_phy, cmd_regad, CODE_TA, cmd_wdata};

  mgmt_clk_gen #(.CLK_DIV(CLK_DIV)) clk_gen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mdc       (mdc),
    .sample_pt (sample_pt),
    .slot_end  (slot_end)
  );

  mgmt_tx_shift #(.W(WBODY_W)) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (tx_word),
    .shift     ((state_q == ST_HDR) && slot_end),
    .msb       (tx_msb)
  );

  assign rx_cap = (state_q == ST_RDATA) && sample_pt && !err_q;

  mgmt_rx_shift #(.W(DATA_W)) rx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (rx_cap),
    .din     (mdio_i),
    .data    (rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      is_rd_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_PRE;
            bcnt_q  <= BW'(PRE_LEN - 1);
            is_rd_q <= cmd_read;
            err_q   <= 1'b0;
          end
        end
        ST_PRE: begin
          if (slot_end) begin
            if (bcnt_q == '0) begin
              state_q <= ST_HDR;
              bcnt_q  <= is_rd_q ? BW'(HDR_LEN - 1) : BW'(WBODY_W - 1);
            end else begin
              bcnt_q <= bcnt_q - 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (slot_end) begin
            if (bcnt_q == '0) begin
              state_q <= is_rd_q ? ST_RIDLE : ST_WIDLE;
            end else begin
              bcnt_q <= bcnt_q - 1'b1;
            end
          end
        end
        ST_WIDLE: if (slot_end) state_q <= ST_DONE;
        ST_RIDLE: if (slot_end) state_q <= ST_ACK;
        ST_ACK: begin
          if (sample_pt) err_q <= mdio_i;
          if (slot_end) begin
            state_q <= ST_RDATA;
            bcnt_q  <= BW'(DATA_W - 1);
          end
        end
        ST_RDATA: begin
          if (slot_end) begin
            if (bcnt_q == '0) begin
              state_q <= ST_TRAIL;
            end else begin
              bcnt_q <= bcnt_q - 1'b1;
            end
          end
        end
        ST_TRAIL: if (slot_end) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mdio_oe = 1'b0;
    mdio_o  = 1'b0;
    case (state_q)
      ST_PRE:   begin mdio_oe = 1'b1; mdio_o = 1'b1;   end
      ST_HDR:   begin mdio_oe = 1'b1; mdio_o = tx_msb; end
      ST_WIDLE: begin mdio_oe = 1'b1; mdio_o = 1'b1;   end
      default:  begin mdio_oe = 1'b0; mdio_o = 1'b0;   end
    endcase
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = (state_q == ST_DONE);
  assign rsp_err   = err_q;
endmodule

// File: rtl/mgmt_serial_master_checker.sv
module mgmt_serial_master_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic rsp_valid,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  assert_accept_starts_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && mdio_oe && mdio_o && !mdc));

  assert_busy_until_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> busy);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && !busy));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_data_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc);

  assert_done_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!mdio_oe && !mdc));
endmodule

bind mgmt_serial_master mgmt_serial_master_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mgmt_serial_master_tb_top.sv
`timescale 1ns/1ps
module mgmt_serial_master_tb_top;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int LAST = 65 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_read = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_regad = '0;
  logic [15:0] cmd_wdata = '0;
  logic        mdio_i = 1'b1;
  logic        cmd_ready, busy, rsp_valid, rsp_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mgmt_serial_master #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_regad(cmd_regad),
    .cmd_wdata(cmd_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                         input logic [15:0] wd, input bit ack_lvl,
                         input logic [15:0] phy_data, input bit hold_valid);
    logic [13:0] hdr;
    logic [15:0] exp_rd;
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
    exp_rd = ack_lvl ? 16'h0000 : phy_data;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_regad = ra; cmd_wdata = wd;
    @(negedge clk);
    if (hold_valid) begin
      // R1: a pending different command while busy must not disturb the frame
      cmd_read = ~rd; cmd_phy = ~phy; cmd_regad = ~ra; cmd_wdata = ~wd;
    end else begin
      cmd_valid = 1'b0;
    end
    for (int k = 0; k <= LAST; k++) begin
      int s, ph;
      bit eoe, eo, lvl;
      string tag;
      if (k > 0) @(negedge clk);
      s = k / DIV; ph = k % DIV;
      eoe = 1'b0; eo = 1'b0; lvl = 1'b1; tag = "R11";
      if (s < 32) begin eoe = 1'b1; eo = 1'b1; tag = "R4"; end
      else if (s < 46) begin eoe = 1'b1; eo = hdr[13 - (s - 32)]; tag = "R5"; end
      else if (!rd && s < 65) begin
        eoe = 1'b1; tag = "R6";
        if (s == 46) eo = 1'b1;
        else if (s == 47) eo = 1'b0;
        else if (s < 64) eo = wd[15 - (s - 48)];
        else eo = 1'b1;
      end else if (rd && s < 65) begin
        tag = (s == 47) ? "R8" : (s >= 48 && s < 64) ? (ack_lvl ? "R10" : "R9") : "R7";
        if (s == 47) lvl = ack_lvl;
        else if (s >= 48 && s < 64) lvl = phy_data[15 - (s - 48)];
      end
      mdio_i = lvl;
      chk(mdc == ((ph >= HALF) && (k < LAST)), "R3", "mdc", mdc, (ph >= HALF) && (k < LAST));
      chk(mdio_oe == eoe, tag, "mdio_oe", mdio_oe, eoe);
      if (eoe) chk(mdio_o == eo, tag, "mdio_o", mdio_o, eo);
      if (rd && s == 46) chk(mdio_o == 1'b0, "R7", "idle low", mdio_o, 0);
      chk(busy == 1'b1, "R2", "busy", busy, 1);
      chk(cmd_ready == 1'b0, "R1", "ready busy", cmd_ready, 0);
      chk(rsp_valid == (k == LAST), "R11", "rsp_valid", rsp_valid, k == LAST);
      if (k == LAST) begin
        cmd_valid = 1'b0;
        if (rd) begin
          chk(rsp_err == ack_lvl, ack_lvl ? "R10" : "R8", "rsp_err", rsp_err, ack_lvl);
          chk(rsp_rdata == exp_rd, ack_lvl ? "R10" : "R9", "rsp_rdata", rsp_rdata, exp_rd);
        end else begin
          chk(rsp_err == 1'b0, "R11", "write err", rsp_err, 0);
        end
      end
    end
    @(negedge clk);
    chk(busy == 1'b0, "R2", "busy after done", busy, 0);
    chk(rsp_valid == 1'b0, "R2", "done one cycle", rsp_valid, 0);
    chk(cmd_ready == 1'b1, "R1", "ready after done", cmd_ready, 1);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R3", "idle pins", {mdc, mdio_oe}, 0);
    mdio_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2", "reset busy", busy, 0);
    chk(rsp_valid == 1'b0, "R2", "reset done", rsp_valid, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R3", "reset pins", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: idle with no request stays idle
    chk(busy == 1'b0, "R1", "no start", busy, 0);
    run_txn(1'b0, 5'h15, 5'h0A, 16'hA5C3, 1'b1, 16'h0000, 1'b0);  // R6 write
    run_txn(1'b1, 5'h01, 5'h1F, 16'h0000, 1'b0, 16'h9E2B, 1'b0);  // R8 R9 read
    run_txn(1'b1, 5'h1E, 5'h02, 16'h0000, 1'b1, 16'hFFFF, 1'b0);  // R10 no ack
    run_txn(1'b1, 5'h00, 5'h00, 16'h0000, 1'b0, 16'hFFFF, 1'b1);  // R1 hold valid
    run_txn(1'b1, 5'h1F, 5'h1F, 16'h0000, 1'b0, 16'h0000, 1'b0);  // R9 zeros
    run_txn(1'b0, 5'h00, 5'h1F, 16'h8001, 1'b1, 16'h0000, 1'b1);  // R6 hold valid
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule